// File: doc/BRIEF.md
# Receive Sample Packet Framer

This block wraps a stream of 32-bit receive sample words into self-describing packets in the VITA-49 style. Each packet leaves on a word-wide valid/ready stream with start and end markers. A packet has a five-word prefix: a header, a stream identifier, a whole-seconds timestamp and a 64-bit fractional timestamp sent as an upper word of zero and a lower word of ticks. The payload words follow, and a trailer word closes the packet. Software-visible configuration supplies four things: the header flag template, the identifier word, the trailer word and the samples-per-packet limit. The hardware fills in the rolling packet counter and the packet length.

A receive command tells the framer how many samples to emit. The framer cuts the command into packets of at most the configured size, and the last packet may be shorter. A channel-count setting makes each sample span one to four consecutive input words. A sticky overrun flag records that samples arrived while the output was stalling the payload, and a clear pulse resets it.

Back-pressure rules are as follows. While `out_ready` is low, a presented prefix or trailer word is held stable with `out_valid` high. Payload words pass straight through from the sample input to the output. During the payload `smp_ready` follows `out_ready`, and at all other times it is low, so a sample is consumed only in the cycle it is accepted downstream.

Top module: `rxf_framer`

## Requirements
- R1: A packet is, in order: header (`out_sop` high), stream identifier, seconds word, fractional upper word 0x00000000, fractional lower word (ticks), payload words, and trailer (`out_eop` high). The identifier and trailer words come from `cfg_stream_id` and `cfg_trailer`. Each payload word equals the accepted `smp_data`.
- R2: The header carries `cfg_header[31:20]` in bits 31:20, the packet counter in bits 19:16 and the total packet length in words (payload words + 6) in bits 15:0. The template's bits 19:0 are discarded.
- R3: The packet counter is 4 bits wide, is 0 for the first packet after reset, and increases by one (modulo 16) for each packet.
- R4: A packet holds min(remaining command samples, samples-per-packet) samples. A `cfg_spp` of 0 counts as 1. A command longer than one packet is split, and its final packet ends early with a correct length.
- R5: Payload words = samples × channels, where the channel code in `cfg_nchan` maps 0 to 1 channel and values above 4 to 4 channels.
- R6: `time_secs` and `time_ticks` are captured in the cycle when a command is pending, the framer is between packets, and `smp_valid` is first high. That sample is the first one of the packet.
- R7: A presented prefix or trailer word stays stable with `out_valid` high while `out_ready` is low. `smp_ready` is high only during the payload, and only while `out_ready` is high.
- R8: `cmd_ready` is high only when no command is pending and no packet is in progress, and no output word is presented while it is high. A command with a sample count of 0 produces no packet.
- R9: Changes to the `cfg_*` inputs after a packet's capture cycle do not affect that packet.
- R10: `overrun` sets when `smp_valid` is high during the payload while `out_ready` is low. It stays set until a cycle with `clr_overrun` high and no set condition, which clears it.
- R11: During reset, `out_valid`, `smp_ready` and `overrun` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_header | input | 32 | Header flag template (bits 31:20 used) |
| cfg_stream_id | input | 32 | Stream identifier word |
| cfg_trailer | input | 32 | Trailer word |
| cfg_spp | input | SPP_W | Samples per packet (0 treated as 1) |
| cfg_nchan | input | 3 | Channel count code (1..4) |
| clr_overrun | input | 1 | Clear pulse for the overrun flag |
| cmd_valid | input | 1 | Receive command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_nsamps | input | CMD_W | Samples requested by the command |
| time_secs | input | 32 | Current whole seconds |
| time_ticks | input | 32 | Current tick count |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Sample word taken |
| smp_data | input | 32 | Sample word |
| out_valid | output | 1 | Packet word offered |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packet word |
| out_sop | output | 1 | Word is a packet header |
| out_eop | output | 1 | Word is a packet trailer |
| overrun | output | 1 | Sticky overrun status |

## Verification
On every cycle, the bound checker covers several port-level rules. It compares each packet's length field with the number of words actually delivered, and checks the counter's step from one header to the next. It also checks that a stalled header holds, that samples move only when accepted downstream and pass through unchanged, that the output stays quiet while a command can be taken, and how the overrun flag behaves when set and cleared. The word-by-word contents of the stream, the timestamp of the first sample, and the split of a command into full packets plus a short final one across channel codes can only be shown by the bench's swept scenarios. The same holds for clamping of the size and channel settings and for immunity to configuration changes mid-packet.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned PKT_CNT_W   = 4;   // header bits 19:16
  localparam int unsigned LEN_W       = 16;  // header bits 15:0
  localparam int unsigned FIXED_WORDS = 6;   // five prefix words plus trailer
  localparam int unsigned NCH_MAX     = 4;
  localparam int unsigned NCH_W       = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_SID,
    S_SECS,
    S_FHI,
    S_FLO,
    S_PAY,
    S_TRL
  } rxf_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] tmpl;
    logic [WORD_W-1:0] sid;
    logic [WORD_W-1:0] trl;
    logic [WORD_W-1:0] secs;
    logic [WORD_W-1:0] ticks;
  } rxf_ctx_t;
endpackage

// File: rtl/rxf_size_calc.sv
`timescale 1ns/1ps
module rxf_size_calc
  import rxf_pkg::*;
#(
  parameter int unsigned SPP_W = 12,
  parameter int unsigned CMD_W = 29
) (
  input  logic [CMD_W-1:0]       rem_i,
  input  logic [SPP_W-1:0]       spp_i,
  input  logic [NCH_W-1:0]       nch_i,
  output logic [SPP_W-1:0]       plen_o,
  output logic [SPP_W+NCH_W-1:0] pwords_o,
  output logic [LEN_W-1:0]       len_o
);
  localparam int unsigned PW_W = SPP_W + NCH_W;

  logic [SPP_W-1:0] spp_eff;
  logic [NCH_W-1:0] nch_eff;

  always_comb begin
    spp_eff = (spp_i == '0) ? SPP_W'(1) : spp_i;
    if (nch_i == '0)
      nch_eff = NCH_W'(1);
    else if (nch_i > NCH_W'(NCH_MAX))
      nch_eff = NCH_W'(NCH_MAX);
    else
      nch_eff = nch_i;
  end

  always_comb begin
    if (rem_i < CMD_W'(spp_eff))
      plen_o = rem_i[SPP_W-1:0];
    else
      plen_o = spp_eff;
    pwords_o = PW_W'(plen_o) * PW_W'(nch_eff);
    len_o    = LEN_W'(pwords_o) + LEN_W'(FIXED_WORDS);
  end
endmodule

// File: rtl/rxf_seq.sv
`timescale 1ns/1ps
module rxf_seq
  import rxf_pkg::*;
#(
  parameter int unsigned SPP_W = 12,
  parameter int unsigned CMD_W = 29
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid_i,
  input  logic [CMD_W-1:0]       cmd_nsamps_i,
  output logic                   cmd_ready_o,
  input  logic                   smp_valid_i,
  input  logic                   out_ready_i,
  input  logic [SPP_W-1:0]       plen_i,
  input  logic [SPP_W+NCH_W-1:0] pwords_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [WORD_W-1:0]      cfg_header_i,
  input  logic [WORD_W-1:0]      cfg_sid_i,
  input  logic [WORD_W-1:0]      cfg_trl_i,
  input  logic [WORD_W-1:0]      time_secs_i,
  input  logic [WORD_W-1:0]      time_ticks_i,
  output rxf_state_e             state_o,
  output logic [CMD_W-1:0]       rem_o,
  output rxf_ctx_t               ctx_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [PKT_CNT_W-1:0]   cnt_o
);
  localparam int unsigned PW_W = SPP_W + NCH_W;

  rxf_state_e           state_q;
  logic [CMD_W-1:0]     rem_q;
  logic [SPP_W-1:0]     plen_q;
  logic [PW_W-1:0]      pw_q;
  logic [PW_W-1:0]      wleft_q;
  logic [LEN_W-1:0]     len_q;
  logic [PKT_CNT_W-1:0] cnt_q;
  rxf_ctx_t             ctx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      plen_q  <= '0;
      pw_q    <= '0;
      wleft_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      ctx_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (rem_q == '0) begin
            if (cmd_valid_i) rem_q <= cmd_nsamps_i;
          end else if (smp_valid_i) begin
            ctx_q.tmpl  <= cfg_header_i;
            ctx_q.sid   <= cfg_sid_i;
            ctx_q.trl   <= cfg_trl_i;
            ctx_q.secs  <= time_secs_i;
            ctx_q.ticks <= time_ticks_i;
            plen_q      <= plen_i;
            pw_q        <= pwords_i;
            len_q       <= len_i;
            state_q     <= S_HDR;
          end
        end
        S_HDR:  if (out_ready_i) state_q <= S_SID;
        S_SID:  if (out_ready_i) state_q <= S_SECS;
        S_SECS: if (out_ready_i) state_q <= S_FHI;
        S_FHI:  if (out_ready_i) state_q <= S_FLO;
        S_FLO: begin
          if (out_ready_i) begin
            wleft_q <= pw_q;
            state_q <= S_PAY;
          end
        end
        S_PAY: begin
          if (smp_valid_i && out_ready_i) begin
            wleft_q <= wleft_q - PW_W'(1);
            if (wleft_q == PW_W'(1)) state_q <= S_TRL;
          end
        end
        S_TRL: begin
          if (out_ready_i) begin
            cnt_q   <= cnt_q + PKT_CNT_W'(1);
            rem_q   <= rem_q - CMD_W'(plen_q);
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE) && (rem_q == '0);
  assign state_o     = state_q;
  assign rem_o       = rem_q;
  assign ctx_o       = ctx_q;
  assign len_o       = len_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/rxf_word_mux.sv
`timescale 1ns/1ps
module rxf_word_mux
  import rxf_pkg::*;
(
  input  rxf_state_e           state_i,
  input  rxf_ctx_t             ctx_i,
  input  logic [PKT_CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [WORD_W-1:0]    smp_data_i,
  output logic [WORD_W-1:0]    word_o
);
  always_comb begin
    unique case (state_i)
      S_HDR:   word_o = {ctx_i.tmpl[WORD_W-1:PKT_CNT_W+LEN_W], cnt_i, len_i};
      S_SID:   word_o = ctx_i.sid;
      S_SECS:  word_o = ctx_i.secs;
      S_FHI:   word_o = '0;
      S_FLO:   word_o = ctx_i.ticks;
      S_PAY:   word_o = smp_data_i;
      S_TRL:   word_o = ctx_i.trl;
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/rxf_ovr_flag.sv
`timescale 1ns/1ps
module rxf_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rxf_framer.sv
`timescale 1ns/1ps
module rxf_framer
  import rxf_pkg::*;
#(
  parameter int unsigned SPP_W = 12,
  parameter int unsigned CMD_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_header,
  input  logic [31:0]      cfg_stream_id,
  input  logic [31:0]      cfg_trailer,
  input  logic [SPP_W-1:0] cfg_spp,
  input  logic [2:0]       cfg_nchan,
  input  logic             clr_overrun,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_nsamps,
  input  logic [31:0]      time_secs,
  input  logic [31:0]      time_ticks,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [31:0]      smp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             overrun
);
  localparam int unsigned PW_W = SPP_W + NCH_W;

  rxf_state_e           state;
  rxf_ctx_t             ctx;
  logic [CMD_W-1:0]     rem;
  logic [SPP_W-1:0]     plen;
  logic [PW_W-1:0]      pwords;
  logic [LEN_W-1:0]     len_next;
  logic [LEN_W-1:0]     len_cur;
  logic [PKT_CNT_W-1:0] pkt_cnt;
  logic                 in_pay;

  rxf_size_calc #(.SPP_W(SPP_W), .CMD_W(CMD_W)) size_i (
    .rem_i    (rem),
    .spp_i    (cfg_spp),
    .nch_i    (cfg_nchan),
    .plen_o   (plen),
    .pwords_o (pwords),
    .len_o    (len_next)
  );

  rxf_seq #(.SPP_W(SPP_W), .CMD_W(CMD_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_nsamps_i (cmd_nsamps),
    .cmd_ready_o  (cmd_ready),
    .smp_valid_i  (smp_valid),
    .out_ready_i  (out_ready),
    .plen_i       (plen),
    .pwords_i     (pwords),
    .len_i        (len_next),
    .cfg_header_i (cfg_header),
    .cfg_sid_i    (cfg_stream_id),
    .cfg_trl_i    (cfg_trailer),
    .time_secs_i  (time_secs),
    .time_ticks_i (time_ticks),
    .state_o      (state),
    .rem_o        (rem),
    .ctx_o        (ctx),
    .len_o        (len_cur),
    .cnt_o        (pkt_cnt)
  );

  rxf_word_mux mux_i (
    .state_i    (state),
    .ctx_i      (ctx),
    .cnt_i      (pkt_cnt),
    .len_i      (len_cur),
    .smp_data_i (smp_data),
    .word_o     (out_data)
  );

  assign in_pay    = (state == S_PAY);
  assign smp_ready = in_pay && out_ready;
  assign out_valid = (state inside {[S_HDR:S_FLO], S_TRL}) || (in_pay && smp_valid);
  assign out_sop   = (state == S_HDR);
  assign out_eop   = (state == S_TRL);

  rxf_ovr_flag ovr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (in_pay && smp_valid && !out_ready),
    .clr_i  (clr_overrun),
    .flag_o (overrun)
  );
endmodule

// File: rtl/rxf_framer_chk.sv
`timescale 1ns/1ps
module rxf_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        clr_overrun,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [31:0] smp_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_sop,
  input logic        out_eop,
  input logic        overrun
);
  logic        seen_q;
  logic [3:0]  last_cnt_q;
  logic [15:0] wcnt_q;
  logic [15:0] len_q;
  logic        xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_cnt_q <= '0;
      wcnt_q     <= '0;
      len_q      <= '0;
    end else if (xfer) begin
      if (out_sop) begin
        seen_q     <= 1'b1;
        last_cnt_q <= out_data[19:16];
        len_q      <= out_data[15:0];
        wcnt_q     <= 16'd1;
      end else begin
        wcnt_q <= wcnt_q + 16'd1;
      end
    end
  end

  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_eop) |-> (wcnt_q + 16'd1 == len_q)); // R2
  AST_CNT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_sop && !seen_q) |-> (out_data[19:16] == 4'd0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_sop && seen_q) |-> (out_data[19:16] == 4'(last_cnt_q + 4'd1))); // R3
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_sop) |=> (out_valid && out_sop && $stable(out_data))); // R7
  AST_SMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> out_ready); // R7
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |-> (out_valid && out_data == smp_data)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !out_valid); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_overrun && !smp_valid) |=> !overrun); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_overrun) |=> overrun); // R10
endmodule

bind rxf_framer rxf_framer_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .clr_overrun (clr_overrun),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .overrun     (overrun)
);

// File: tb/rxf_framer_tb_top.sv
`timescale 1ns/1ps
module rxf_framer_tb_top;
  localparam int SPP_W = 12;
  localparam int CMD_W = 29;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      cfg_header = '0;
  logic [31:0]      cfg_stream_id = '0;
  logic [31:0]      cfg_trailer = '0;
  logic [SPP_W-1:0] cfg_spp = '0;
  logic [2:0]       cfg_nchan = '0;
  logic             clr_overrun = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [CMD_W-1:0] cmd_nsamps = '0;
  logic [31:0]      time_secs = '0;
  logic [31:0]      time_ticks;
  logic             smp_valid;
  logic             smp_ready;
  logic [31:0]      smp_data;
  logic             out_valid;
  logic             out_ready;
  logic [31:0]      out_data;
  logic             out_sop;
  logic             out_eop;
  logic             overrun;

  always #10 clk = ~clk;

  rxf_framer #(.SPP_W(SPP_W), .CMD_W(CMD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_header(cfg_header), .cfg_stream_id(cfg_stream_id),
    .cfg_trailer(cfg_trailer), .cfg_spp(cfg_spp), .cfg_nchan(cfg_nchan),
    .clr_overrun(clr_overrun), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_nsamps(cmd_nsamps), .time_secs(time_secs), .time_ticks(time_ticks),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .overrun(overrun)
  );

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] cyc     = '0;
  logic [31:0] src_w   = '0;   // index of the sample word at the head of the source
  logic [31:0] exp_w   = '0;   // next payload word index expected
  logic [3:0]  exp_pc  = '0;
  int          words_seen = 0;
  int          sop_seen   = 0;
  bit          src_on = 1'b0;
  bit          rdy_pat = 1'b0;
  bit          rdy_low = 1'b0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  assign smp_data   = 32'hD000_0000 + src_w;
  assign time_ticks = 32'h0000_1000 + src_w;
  assign smp_valid  = src_on && ((cyc % 5) != 3);
  assign out_ready  = !rdy_low && (!rdy_pat || ((cyc % 7) != 2));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (smp_valid && smp_ready) src_w <= src_w + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      words_seen++;
      if (out_sop) sop_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected word", {30'd0, out_sop, out_eop, out_data}, 64'd0);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_sop, out_eop, out_data} == e, t, {30'd0, out_sop, out_eop, out_data}, {30'd0, e});
      end
    end
  end

  task automatic push(input bit s, input bit e, input logic [31:0] d, input string t);
    exp_q.push_back({s, e, d});
    tag_q.push_back(t);
  endtask

  // Expected stream of one command under the present configuration.
  task automatic plan_cmd(input int ns, input string extra);
    int spp_e;
    int nch_e;
    int rem;
    int pl;
    int pw;
    spp_e = (cfg_spp == 0) ? 1 : int'(cfg_spp);
    nch_e = (cfg_nchan == 0) ? 1 : ((cfg_nchan > 4) ? 4 : int'(cfg_nchan));
    rem = ns;
    while (rem > 0) begin
      pl = (rem < spp_e) ? rem : spp_e;
      pw = pl * nch_e;
      push(1'b1, 1'b0, {cfg_header[31:20], exp_pc, 16'(pw + 6)}, {"R2 R3 R4 R5 header ", extra});
      push(1'b0, 1'b0, cfg_stream_id, {"R1 stream id ", extra});
      push(1'b0, 1'b0, time_secs, "R6 seconds");
      push(1'b0, 1'b0, 32'd0, "R1 fraction upper");
      push(1'b0, 1'b0, 32'h0000_1000 + exp_w, "R6 ticks");
      for (int i = 0; i < pw; i++)
        push(1'b0, 1'b0, 32'hD000_0000 + exp_w + 32'(i), "R4 R5 payload");
      push(1'b0, 1'b1, cfg_trailer, {"R1 trailer ", extra});
      exp_pc = exp_pc + 4'd1;
      exp_w  = exp_w + 32'(pw);
      rem    = rem - pl;
    end
  endtask

  task automatic issue_cmd(input int ns);
    while (!cmd_ready) @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_nsamps = CMD_W'(ns);
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (exp_q.size() != 0 || !cmd_ready);
  endtask

  task automatic run_cmd(input int ns, input string extra);
    plan_cmd(ns, extra);
    issue_cmd(ns);
    wait_done();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int nch_set[5] = '{0, 1, 2, 4, 7};
    int spp_set[4] = '{0, 1, 3, 5};
    int ns_set[3]  = '{1, 4, 7};
    int k;
    int ws;
    int s0;
    logic [31:0] held;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid in reset", 64'(out_valid), 64'd0);
    chk(smp_ready == 1'b0, "R11 smp_ready in reset", 64'(smp_ready), 64'd0);
    chk(overrun == 1'b0, "R11 overrun in reset", 64'(overrun), 64'd0);
    chk(cmd_ready == 1'b1, "R11 cmd_ready in reset", 64'(cmd_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: no back-pressure, no overrun
    src_on = 1'b1;
    cfg_header = 32'h1460_0000; cfg_stream_id = 32'h0000_0042; cfg_trailer = 32'h0000_0099;
    cfg_spp = 12'd2; cfg_nchan = 3'd1; time_secs = 32'h0000_0500;
    run_cmd(3, "R4 short tail");
    chk(overrun == 1'b0, "R10 overrun without stall", 64'(overrun), 64'd0);

    // Sweep: channel codes, packet sizes, command lengths, with output stalls
    rdy_pat = 1'b1;
    k = 0;
    foreach (nch_set[a]) foreach (spp_set[b]) foreach (ns_set[c]) begin
      cfg_nchan     = 3'(nch_set[a]);
      cfg_spp       = SPP_W'(spp_set[b]);
      cfg_header    = {12'(12'h145 + k), 20'hABCDE};
      cfg_stream_id = 32'h5100_0000 + 32'(k);
      cfg_trailer   = 32'h7A00_0000 + 32'(k);
      time_secs     = 32'h0000_0600 + 32'(k);
      run_cmd(ns_set[c], "sweep");
      k++;
    end
    chk(overrun == 1'b1, "R10 overrun after stalled payload", 64'(overrun), 64'd1);

    // R10: clear
    src_on = 1'b0; rdy_pat = 1'b0;
    @(negedge clk);
    clr_overrun = 1'b1;
    @(negedge clk);
    clr_overrun = 1'b0;
    chk(overrun == 1'b0, "R10 overrun cleared", 64'(overrun), 64'd0);

    // R8: zero-length command produces nothing
    src_on = 1'b1;
    ws = words_seen;
    issue_cmd(0);
    repeat (20) @(negedge clk);
    chk(words_seen == ws, "R8 zero command emitted words", 64'(words_seen - ws), 64'd0);
    chk(cmd_ready == 1'b1, "R8 ready after zero command", 64'(cmd_ready), 64'd1);

    // R7: header held under back-pressure
    cfg_spp = 12'd4; cfg_nchan = 3'd1; time_secs = 32'h0000_0700;
    plan_cmd(2, "R7");
    rdy_low = 1'b1;
    issue_cmd(2);
    while (!(out_valid && out_sop)) @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_sop && out_data == held, "R7 header held", {31'd0, out_valid, out_data}, {31'd1, held});
    chk(smp_ready == 1'b0, "R7 no sample taken while stalled", 64'(smp_ready), 64'd0);
    rdy_low = 1'b0;
    wait_done();

    // R9: configuration changed after capture
    cfg_spp = 12'd8; cfg_nchan = 3'd2; time_secs = 32'h0000_0800;
    cfg_stream_id = 32'h0BAD_0001; cfg_trailer = 32'h0BAD_0002; cfg_header = 32'h1460_0000;
    plan_cmd(3, "R9");
    s0 = sop_seen;
    issue_cmd(3);
    while (sop_seen == s0) @(negedge clk);
    chk(cmd_ready == 1'b0, "R8 ready while packet in flight", 64'(cmd_ready), 64'd0);
    cfg_stream_id = 32'hFFFF_0001; cfg_trailer = 32'hFFFF_0002; cfg_header = 32'hFFF0_0000;
    cfg_spp = 12'd1; cfg_nchan = 3'd1;
    wait_done();
    chk(exp_q.size() == 0, "R9 stream complete", 64'(exp_q.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule